// File: doc/BRIEF.md
# Stream Lane Activity Decoder

This block sits at the receiving end of a multi-lane element stream. Each transfer carries one element per lane plus three qualifiers: a start index, an end index and a strobe. The block reduces these qualifiers to a single per-lane activity mask. The mask leaves through a registered valid/ready stage, together with the unchanged lane data and a flag that marks a transfer with no active lane.

Sources differ in how they mark activity. Simpler sources drive one strobe bit for the whole transfer and restrict the active lanes with the index pair. Richer sources drive one strobe bit per lane. A fixed precedence rule combines the two. The index pair matters only while every strobe bit is high. As soon as any strobe bit is low, the strobe bits alone decide which lanes are active. A sink built for either strobe width therefore accepts traffic from both kinds of source.

Top module: `lane_activity_decoder`

## Requirements
- R1: With CPLX below 7 (a single strobe bit), a transfer whose strobe bit is 0 produces an all-zero mask and a set empty flag, whatever the index values are.
- R2: With CPLX below 7 and the strobe bit at 1, lane i is active exactly when in_start <= i <= in_end.
- R3: With CPLX of 7 or more, strobe bit i belongs to lane i (bit 0 is lane 0). If any strobe bit is 0, the output mask equals the strobe and the indices are ignored; strobe 5'b01010 with both indices at 0 gives exactly lanes 1 and 3.
- R4: When every strobe bit is 1, lane i is active exactly when in_start <= i <= in_end.
- R5: When every strobe bit is 1 and in_start > in_end, the mask is all zeros and the empty flag is set.
- R6: While out_valid is 1, out_empty is 1 exactly when out_active is all zeros.
- R7: A transfer is accepted on a rising edge with in_valid and in_ready both 1. From the next cycle, out_valid is 1 and out_data equals the accepted in_data, bit for bit.
- R8: in_ready is 1 exactly when out_valid is 0 or out_ready is 1. While out_valid is 1 and out_ready is 0, out_data, out_active and out_empty hold their values. A consumed output with no new input drops out_valid.
- R9: A clock edge with rst_n low clears out_valid, out_active and out_empty.
- R10: Every strobe bit at 1 with in_start = 0 and in_end = LANES-1 marks all lanes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Input transfer can be taken |
| in_data | input | LANES*ELEM_W | Lane elements, lane 0 in the low bits |
| in_start | input | $clog2(LANES) | First active lane index |
| in_end | input | $clog2(LANES) | Last active lane index |
| in_strobe | input | LANES if CPLX>=7, else 1 | Per-lane or whole-transfer strobe |
| out_valid | output | 1 | Output transfer offered |
| out_ready | input | 1 | Output transfer consumed |
| out_data | output | LANES*ELEM_W | Lane elements, unchanged |
| out_active | output | LANES | Per-lane activity mask |
| out_empty | output | 1 | No lane active in this transfer |

## Verification
The hardest case to reach is a change of input while the output is stalled. A transfer held with out_ready low must keep its mask even though in_valid and the qualifiers change underneath it. This case also covers the cycle where a stalled output is consumed and refilled on the same edge. The stimulus holds out_ready low for several cycles and keeps changing the input qualifiers, then mixes random back-pressure with strobe patterns that are biased so that about half of them are all ones. Two instances run side by side, one with a single strobe bit and one with per-lane strobes, and both see the same index values. Reversed ranges, the 01010 pattern with zero indices and the full range therefore all reach the precedence rule of each variant.

// File: rtl/lad_pkg.sv
// Package: shared constants and helpers for the lane activity decoder.
// Assumes: complexity levels are small non-negative integers.
package lad_pkg;

    // Complexity level from which the strobe carries one bit per lane
    localparam int unsigned FULL_STROBE_LEVEL = 7;

    // Width of the strobe input for a given lane count and complexity
    function automatic int unsigned strobe_width(int unsigned lanes, int unsigned cplx);
        return (cplx >= FULL_STROBE_LEVEL) ? lanes : 1;
    endfunction

endpackage

// File: rtl/lad_strobe_expand.sv
// Module: widens the incoming strobe into one bit per lane.
// Per-lane strobes pass straight through. A single whole-transfer strobe
// is copied onto every lane, so later logic treats both variants alike.
// Assumes: STRB_W is either LANES or 1.
module lad_strobe_expand #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned STRB_W = 8
) (
    input  logic [STRB_W-1:0] strobe,
    output logic [LANES-1:0]  lane_strobe
);

    generate
        if (STRB_W == LANES) begin : g_per_lane
            // Purpose: per-lane strobe is used as is
            always_comb lane_strobe = strobe;
        end else begin : g_single
            // Purpose: copy the single strobe bit onto every lane
            always_comb lane_strobe = {LANES{strobe[0]}};
        end
    endgenerate

endmodule

// File: rtl/lad_range_mask.sv
// Module: builds the lane mask covered by an inclusive index window.
// Lane i is set when first <= i <= last. A reversed window (first > last)
// gives no lane at all.
// Assumes: LANES >= 2; indices are IDX_W bits wide.
module lad_range_mask #(
    parameter int unsigned LANES = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [IDX_W-1:0] first,
    input  logic [IDX_W-1:0] last,
    output logic [LANES-1:0] in_window
);

    generate
        for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
            logic above_first;
            logic below_last;
            // Purpose: compare this lane's position against both window bounds
            always_comb begin
                above_first = (int'(first) <= lane);
                below_last  = (lane <= int'(last));
            end
            // Purpose: the lane lies in the window when both bounds hold
            always_comb in_window[lane] = above_first & below_last;
        end
    endgenerate

endmodule

// File: rtl/lad_out_stage.sv
// Module: one-deep registered valid/ready stage for the decoded transfer.
// Takes a new transfer when empty or when the held one leaves this cycle,
// and holds everything stable under back-pressure.
// Assumes: synchronous active-low reset; payload is not reset.
module lad_out_stage #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    input  logic [LANES-1:0]  up_active,
    input  logic              up_empty,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data,
    output logic [LANES-1:0]  dn_active,
    output logic              dn_empty
);

    logic take;

    // Purpose: room exists when nothing is held or the held transfer leaves now
    always_comb up_ready = ~dn_valid | dn_ready;

    // Purpose: a transfer moves in when offered and there is room
    always_comb take = up_valid & up_ready;

    // Purpose: valid flag and qualifier registers, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid  <= 1'b0;
            dn_active <= '0;
            dn_empty  <= 1'b0;
        end else if (take) begin
            dn_valid  <= 1'b1;
            dn_active <= up_active;
            dn_empty  <= up_empty;
        end else if (dn_ready) begin
            dn_valid  <= 1'b0;
        end
    end

    // Purpose: lane data register, loaded only on a take
    always_ff @(posedge clk) begin
        if (take) begin
            dn_data <= up_data;
        end
    end

endmodule

// File: rtl/lane_activity_decoder.sv
// Module: top of the lane activity decoder.
// Widens the strobe, builds the index-window mask, applies the precedence
// rule (the window counts only under a full strobe, otherwise the strobe
// decides), flags empty transfers and registers the result.
// Assumes: LANES >= 2; CPLX picks a single (below 7) or per-lane strobe.
module lane_activity_decoder #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned ELEM_W = 8,
    parameter int unsigned CPLX   = 7,
    localparam int unsigned IDX_W  = $clog2(LANES),
    localparam int unsigned DATA_W = LANES * ELEM_W,
    localparam int unsigned STRB_W = lad_pkg::strobe_width(LANES, CPLX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [IDX_W-1:0]  in_start,
    input  logic [IDX_W-1:0]  in_end,
    input  logic [STRB_W-1:0] in_strobe,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [LANES-1:0]  out_active,
    output logic              out_empty
);

    logic [LANES-1:0] lane_strobe;
    logic [LANES-1:0] window_mask;
    logic [LANES-1:0] next_active;
    logic             strobe_full;
    logic             next_empty;

    lad_strobe_expand #(
        .LANES  (LANES),
        .STRB_W (STRB_W)
    ) u_expand (
        .strobe      (in_strobe),
        .lane_strobe (lane_strobe)
    );

    lad_range_mask #(
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) u_window (
        .first     (in_start),
        .last      (in_end),
        .in_window (window_mask)
    );

    // Purpose: precedence rule, the window applies only under a full strobe
    always_comb begin
        strobe_full = &lane_strobe;
        next_active = strobe_full ? window_mask : lane_strobe;
    end

    // Purpose: a transfer is empty when no lane remains active
    always_comb next_empty = ~|next_active;

    lad_out_stage #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_valid  (in_valid),
        .up_ready  (in_ready),
        .up_data   (in_data),
        .up_active (next_active),
        .up_empty  (next_empty),
        .dn_valid  (out_valid),
        .dn_ready  (out_ready),
        .dn_data   (out_data),
        .dn_active (out_active),
        .dn_empty  (out_empty)
    );

endmodule

// File: rtl/lane_activity_decoder_chk.sv
// Checker: port-level properties of the lane activity decoder, bound below.
// Assumes: the same parameters as the decoder instance it watches.
module lane_activity_decoder_chk #(
    parameter int unsigned LANES  = 8,
    parameter int unsigned ELEM_W = 8,
    parameter int unsigned CPLX   = 7,
    localparam int unsigned IDX_W  = $clog2(LANES),
    localparam int unsigned DATA_W = LANES * ELEM_W,
    localparam int unsigned STRB_W = lad_pkg::strobe_width(LANES, CPLX)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic [IDX_W-1:0]  in_start,
    input logic [IDX_W-1:0]  in_end,
    input logic [STRB_W-1:0] in_strobe,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [LANES-1:0]  out_active,
    input logic              out_empty
);

    logic accept;
    always_comb accept = in_valid & in_ready;

    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_active == '0 && !out_empty));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && rst_n) |=>
            (out_valid && $stable(out_data) && $stable(out_active) && $stable(out_empty)));

    assert_empty_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_empty == (out_active == '0)));

    assert_data_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (out_valid && out_data == $past(in_data)));

    assert_window_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (&in_strobe) && in_start <= in_end) |=>
            (out_active[$past(in_start)] && out_active[$past(in_end)]));

    assert_reversed_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (&in_strobe) && in_start > in_end) |=> (out_empty && out_active == '0));

    generate
        if (STRB_W == LANES) begin : g_per_lane
            assert_partial_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (accept && !(&in_strobe)) |=> (out_active == $past(in_strobe)));
        end else begin : g_single
            assert_off_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (accept && !in_strobe[0]) |=> (out_empty && out_active == '0));
        end
    endgenerate

endmodule

bind lane_activity_decoder lane_activity_decoder_chk #(
    .LANES  (LANES),
    .ELEM_W (ELEM_W),
    .CPLX   (CPLX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_start   (in_start),
    .in_end     (in_end),
    .in_strobe  (in_strobe),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_active (out_active),
    .out_empty  (out_empty)
);

// File: tb/test_lane_activity_decoder.sv
`timescale 1ns/1ps
// Bench: two decoders (per-lane strobe and single strobe) against a
// behavioural reference model, compared on every falling clock edge.
module test_lane_activity_decoder;

    localparam int LN = 8;
    localparam int EW = 8;
    localparam int IW = $clog2(LN);
    localparam int DW = LN * EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [IW-1:0] in_start = '0;
    logic [IW-1:0] in_end = '0;
    logic [LN-1:0] hi_strobe = '0;
    logic          lo_strobe = 1'b0;
    logic          out_ready = 1'b0;

    logic          rdy [2];
    logic          ov [2];
    logic [DW-1:0] od [2];
    logic [LN-1:0] oa [2];
    logic          oe [2];

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lane_activity_decoder #(.LANES(LN), .ELEM_W(EW), .CPLX(7)) i_lane_activity_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]),
        .in_data(in_data), .in_start(in_start), .in_end(in_end), .in_strobe(hi_strobe),
        .out_valid(ov[0]), .out_ready(out_ready), .out_data(od[0]),
        .out_active(oa[0]), .out_empty(oe[0]));

    lane_activity_decoder #(.LANES(LN), .ELEM_W(EW), .CPLX(3)) i_lane_activity_decoder_lo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]),
        .in_data(in_data), .in_start(in_start), .in_end(in_end), .in_strobe(lo_strobe),
        .out_valid(ov[1]), .out_ready(out_ready), .out_data(od[1]),
        .out_active(oa[1]), .out_empty(oe[1]));

    // Reference model state per instance (0: per-lane strobe, 1: single strobe)
    bit            m_valid [2];
    logic [LN-1:0] m_mask [2];
    bit            m_empty [2];
    logic [DW-1:0] m_data [2];
    string         m_tag [2];

    function automatic logic [LN-1:0] ref_mask(logic [LN-1:0] s, int st, int en);
        logic [LN-1:0] m = '0;
        if (s != {LN{1'b1}}) return s;
        for (int i = 0; i < LN; i++) if (i >= st && i <= en) m[i] = 1'b1;
        return m;
    endfunction

    function automatic string ref_tag(bit lo, logic [LN-1:0] s, int st, int en);
        if (lo && s == '0) return "R1";
        if (s != {LN{1'b1}}) return "R3";
        if (st > en) return "R5";
        if (st == 0 && en == LN - 1) return "R10";
        return lo ? "R2" : "R4";
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            logic [LN-1:0] s;
            s = (k == 0) ? hi_strobe : {LN{lo_strobe}};
            if (!rst_n) begin
                m_valid[k] = 0; m_mask[k] = '0; m_empty[k] = 0;
            end else if (in_valid && (!m_valid[k] || out_ready)) begin
                m_valid[k] = 1;
                m_mask[k]  = ref_mask(s, int'(in_start), int'(in_end));
                m_empty[k] = (m_mask[k] == '0);
                m_data[k]  = in_data;
                m_tag[k]   = ref_tag(k == 1, s, int'(in_start), int'(in_end));
            end else if (out_ready) begin
                m_valid[k] = 0;
            end
        end
    end

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        for (int k = 0; k < 2; k++) begin
            check("R8", "out_valid", DW'(ov[k]), DW'(m_valid[k]));
            if (m_valid[k]) begin
                check(m_tag[k], "out_active", DW'(oa[k]), DW'(m_mask[k]));
                check("R6", "out_empty", DW'(oe[k]), DW'(m_empty[k]));
                check("R7", "out_data", od[k], m_data[k]);
            end
        end
    endtask

    task automatic step(bit v, logic [LN-1:0] hs, bit ls, int st, int en, bit rd);
        @(negedge clk);
        compare_outputs();
        in_valid = v; hi_strobe = hs; lo_strobe = ls;
        in_start = IW'(st); in_end = IW'(en); out_ready = rd;
        in_data = {$urandom, $urandom};
        #1;
        for (int k = 0; k < 2; k++)
            check("R8", "in_ready", DW'(rdy[k]), DW'(!m_valid[k] || out_ready));
    endtask

    task automatic reset_check();
        for (int k = 0; k < 2; k++) begin
            check("R9", "out_valid reset", DW'(ov[k]), '0);
            check("R9", "out_active reset", DW'(oa[k]), '0);
            check("R9", "out_empty reset", DW'(oe[k]), '0);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        // R1/R3: strobe low with indices set; 01010 with zero indices
        step(1, 8'b0000_1010, 0, 0, 0, 1);
        step(1, 8'b0000_0000, 0, 2, 6, 1);
        // R4/R2: full strobe, inner window and single lane
        step(1, 8'hFF, 1, 2, 5, 1);
        step(1, 8'hFF, 1, 4, 4, 1);
        // R10: full range
        step(1, 8'hFF, 1, 0, LN - 1, 1);
        // R5: reversed window
        step(1, 8'hFF, 1, 6, 1, 1);
        // R8: stall while inputs keep changing
        step(1, 8'b1101_0010, 1, 1, 3, 0);
        step(1, 8'hFF, 0, 0, 7, 0);
        step(1, 8'h0F, 1, 3, 3, 0);
        step(0, 8'h00, 0, 0, 0, 0);
        step(1, 8'hFF, 1, 1, 6, 1);
        step(0, 8'h00, 0, 0, 0, 1);
        step(0, 8'h00, 0, 0, 0, 1);
        // Random traffic with back-pressure
        for (int n = 0; n < 4000; n++) begin
            logic [LN-1:0] hs;
            hs = ($urandom_range(0, 1) == 1) ? 8'hFF : LN'($urandom);
            step($urandom_range(0, 3) != 0, hs, $urandom_range(0, 2) != 0,
                 $urandom_range(0, LN - 1), $urandom_range(0, LN - 1),
                 $urandom_range(0, 9) < 7);
        end
        // R9: reset while data is held
        step(1, 8'hFF, 1, 0, 3, 0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        reset_check();
        rst_n = 1'b1;
        step(0, 8'h00, 0, 0, 0, 1);
        step(0, 8'h00, 0, 0, 0, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule